// File: doc/BRIEF.md
# Event ID Matching Controller

This block keeps a trigger system and a set of readout channels in step, one event at a time. Event identifiers (36 bits) arrive from a trigger receiver and wait in a small FIFO. The controller takes the oldest waiting identifier as its current event. It gives each new current event a fresh 4-bit request tag. It then broadcasts a request word to every channel, and repeats the broadcast at a programmable interval until all enabled channels have reported the current event.

Replies come in already decoded: a channel number, a request tag and an event identifier. A reply that carries the live tag and the current identifier sets that channel's matched flag. Once every enabled channel is matched, the controller moves on to the next event. A host write port controls a halt mode, which is set after reset. While halted the controller sends no requests. A host strobe can still discard the current event and load the next one. Status outputs show the current and newest identifiers, the FIFO occupancy, the request tag, the retry count and the matched flags.

Top module: `evt_match_ctrl`

## Requirements
- R1: Each `evt_valid_i` pulse queues `evt_id_i` in first-in first-out order and updates `newest_evt_o`. `fifo_cnt_o` counts only the queued entries and never includes the current event.
- R2: If an identifier arrives while the FIFO holds `DEPTH` entries, it is dropped. `overflow_o` then sets and stays set until reset, and `fifo_cnt_o` never exceeds `DEPTH`.
- R3: Loading a new current event does four things: `req_id_o` increments with wrap from 15 to 0 (the first event gets tag 1), `retry_cnt_o` clears to 0, every bit of `matched_o` clears, and `cur_valid_o` goes to 1. When not halted and no event is current, the oldest FIFO entry is loaded.
- R4: A request is a one-cycle `req_valid_o` pulse. `req_word_o[15:8]` is 0xFF, a channel number at or above the channel count, which means broadcast. `req_word_o[7:0]` is the request tag, zero-extended. Each pulse adds 1 to `retry_cnt_o`. The first pulse follows the load by one cycle.
- R5: While the current event is unmatched and the controller is not halted, the rising edges of consecutive request pulses are `interval_o + 2` clock cycles apart.
- R6: A reply sets `matched_o[ch]` only if its tag equals `req_id_o` and its identifier equals `cur_evt_o`. Replies with a stale tag or a different identifier leave `matched_o` unchanged.
- R7: When every channel with its `chan_en_o` bit set is matched, the controller loads the next event. If the FIFO is empty, `cur_valid_o` drops to 0 instead. Disabled channels are left out of this check.
- R8: `halt_o` resets to 1. One cycle after halt is in effect, no further request pulses are sent.
- R9: Host address 1 with data bit 0 set is the force strobe. While halted with a current event, it loads the next FIFO entry (or clears `cur_valid_o` if the FIFO is empty), even if the current event is unmatched. When the controller is not halted, the strobe has no effect.
- R10: Host writes use address 0 for halt (bit 0), address 2 for the interval, and address 3 for the channel enables (bits CH_N-1:0). Reset values are halt 1, interval 0x07FF, and all channels enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | New event identifier strobe |
| evt_id_i | input | ID_W | Event identifier from the trigger receiver |
| reply_valid_i | input | 1 | Decoded reply strobe |
| reply_ch_i | input | 8 | Channel that sent the reply |
| reply_rid_i | input | RID_W | Request tag carried by the reply |
| reply_evt_i | input | ID_W | Event identifier carried by the reply |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | 16 | Host write data |
| req_valid_o | output | 1 | Request word valid |
| req_word_o | output | 16 | Request word: channel field and tag |
| cur_valid_o | output | 1 | A current event is held |
| cur_evt_o | output | ID_W | Event identifier being matched |
| newest_evt_o | output | ID_W | Identifier received most recently |
| fifo_cnt_o | output | CNT_W | Queued identifiers, excluding the current one |
| overflow_o | output | 1 | Sticky FIFO overflow flag |
| req_id_o | output | RID_W | Current request tag |
| retry_cnt_o | output | RET_W | Requests sent for the current event |
| matched_o | output | CH_N | Per-channel matched flags |
| halt_o | output | 1 | Halt setting |
| interval_o | output | INT_W | Re-request interval setting |
| chan_en_o | output | CH_N | Channel enables |

## Verification
The controller's state is held in its tag counter, matched flags, FIFO pointers and sequencer state. A fault in any of these shows at the ports within a few cycles. A missed tag increment or matched clear shows on `req_id_o` and `matched_o` in the same cycle as the load. A wrong FIFO pointer delivers the wrong identifier on the next load or force, and those happen one clock after the strobe. A wrong interval timer moves the spacing of the next request pulse, and the bench measures that spacing exactly.

// File: rtl/evm_pkg.sv
package evm_pkg;
  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_IDLE = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;

  localparam logic [1:0] ADDR_HALT     = 2'd0;
  localparam logic [1:0] ADDR_FORCE    = 2'd1;
  localparam logic [1:0] ADDR_INTERVAL = 2'd2;
  localparam logic [1:0] ADDR_CHAN_EN  = 2'd3;

  localparam logic [7:0] BCAST_CH = 8'hFF;
endpackage

// File: rtl/evm_fifo.sv
module evm_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
      // full is judged on the registered count, even when a pop coincides
      if (push_i && full) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/evm_host.sv
module evm_host
  import evm_pkg::*;
#(
  parameter int              CH_N    = 4,
  parameter int              INT_W   = 16,
  parameter logic [INT_W-1:0] DEF_INT = INT_W'(16'h07FF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [15:0]      wr_data_i,
  output logic             halt_o,
  output logic             force_o,
  output logic [INT_W-1:0] interval_o,
  output logic [CH_N-1:0]  chan_en_o
);
  assign force_o = wr_en_i && (wr_addr_i == ADDR_FORCE) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o     <= 1'b1;
      interval_o <= DEF_INT;
      chan_en_o  <= '1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_HALT:     halt_o     <= wr_data_i[0];
        ADDR_INTERVAL: interval_o <= wr_data_i[INT_W-1:0];
        ADDR_CHAN_EN:  chan_en_o  <= wr_data_i[CH_N-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evm_match.sv
module evm_match #(
  parameter int CH_N  = 4,
  parameter int ID_W  = 36,
  parameter int RID_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             cur_valid_i,
  input  logic [ID_W-1:0]  cur_evt_i,
  input  logic [RID_W-1:0] rid_i,
  input  logic             reply_valid_i,
  input  logic [7:0]       reply_ch_i,
  input  logic [RID_W-1:0] reply_rid_i,
  input  logic [ID_W-1:0]  reply_evt_i,
  input  logic [CH_N-1:0]  chan_en_i,
  output logic [CH_N-1:0]  matched_o,
  output logic             all_matched_o
);
  logic good_reply;

  assign good_reply = reply_valid_i && cur_valid_i &&
                      (reply_rid_i == rid_i) && (reply_evt_i == cur_evt_i);

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     matched_o[g] <= 1'b0;
      else if (clear_i)                                matched_o[g] <= 1'b0;
      else if (good_reply && reply_ch_i == 8'(g))      matched_o[g] <= 1'b1;
    end
  end

  assign all_matched_o = cur_valid_i && (&(matched_o | ~chan_en_i));
endmodule

// File: rtl/evm_seq.sv
module evm_seq
  import evm_pkg::*;
#(
  parameter int ID_W  = 36,
  parameter int RID_W = 4,
  parameter int INT_W = 16,
  parameter int RET_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             force_i,
  input  logic [INT_W-1:0] interval_i,
  input  logic             empty_i,
  input  logic [ID_W-1:0]  head_i,
  input  logic             all_matched_i,
  output logic             load_o,
  output logic             cur_valid_o,
  output logic [ID_W-1:0]  cur_evt_o,
  output logic [RID_W-1:0] rid_o,
  output logic [RET_W-1:0] retry_o,
  output logic             req_o
);
  seq_state_e       state_q, state_d;
  logic [INT_W-1:0] timer_q;
  logic             load, drop;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    drop    = 1'b0;
    case (state_q)
      ST_HALT: begin
        if (!halt_i) state_d = cur_valid_o ? ST_REQ : ST_IDLE;
        else if (force_i && cur_valid_o) begin
          if (!empty_i) load = 1'b1;
          else          drop = 1'b1;
        end
      end
      ST_IDLE: begin
        if (halt_i) state_d = ST_HALT;
        else if (!empty_i) begin
          load    = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: state_d = halt_i ? ST_HALT : ST_WAIT;
      ST_WAIT: begin
        if (halt_i) state_d = ST_HALT;
        else if (all_matched_i) begin
          if (!empty_i) begin
            load    = 1'b1;
            state_d = ST_REQ;
          end else begin
            drop    = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (timer_q == '0) state_d = ST_REQ;
      end
      default: state_d = ST_HALT;
    endcase
  end

  assign load_o = load;
  assign req_o  = (state_q == ST_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HALT;
      timer_q     <= '0;
      cur_valid_o <= 1'b0;
      cur_evt_o   <= '0;
      rid_o       <= '0;
      retry_o     <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        cur_valid_o <= 1'b1;
        cur_evt_o   <= head_i;
        rid_o       <= rid_o + RID_W'(1);
        retry_o     <= '0;
      end else if (drop) begin
        cur_valid_o <= 1'b0;
      end
      if (state_q == ST_REQ) begin
        retry_o <= retry_o + RET_W'(1);
        timer_q <= interval_i;
      end else if (state_q == ST_WAIT && timer_q != '0) begin
        timer_q <= timer_q - INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/evt_match_ctrl.sv
module evt_match_ctrl
  import evm_pkg::*;
#(
  parameter int              ID_W    = 36,
  parameter int              CH_N    = 4,
  parameter int              DEPTH   = 8,
  parameter int              RID_W   = 4,
  parameter int              INT_W   = 16,
  parameter int              RET_W   = 16,
  parameter logic [INT_W-1:0] DEF_INT = INT_W'(16'h07FF),
  localparam int             CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [ID_W-1:0]  evt_id_i,
  input  logic             reply_valid_i,
  input  logic [7:0]       reply_ch_i,
  input  logic [RID_W-1:0] reply_rid_i,
  input  logic [ID_W-1:0]  reply_evt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [15:0]      wr_data_i,
  output logic             req_valid_o,
  output logic [15:0]      req_word_o,
  output logic             cur_valid_o,
  output logic [ID_W-1:0]  cur_evt_o,
  output logic [ID_W-1:0]  newest_evt_o,
  output logic [CNT_W-1:0] fifo_cnt_o,
  output logic             overflow_o,
  output logic [RID_W-1:0] req_id_o,
  output logic [RET_W-1:0] retry_cnt_o,
  output logic [CH_N-1:0]  matched_o,
  output logic             halt_o,
  output logic [INT_W-1:0] interval_o,
  output logic [CH_N-1:0]  chan_en_o
);
  logic            force_w, load_w, empty_w, all_matched_w;
  logic [ID_W-1:0] head_w;

  evm_host #(.CH_N(CH_N), .INT_W(INT_W), .DEF_INT(DEF_INT)) i_host (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .halt_o, .force_o(force_w), .interval_o, .chan_en_o
  );

  evm_fifo #(.W(ID_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(evt_valid_i), .data_i(evt_id_i), .pop_i(load_w),
    .data_o(head_w), .empty_o(empty_w), .cnt_o(fifo_cnt_o), .ovf_o(overflow_o)
  );

  evm_seq #(.ID_W(ID_W), .RID_W(RID_W), .INT_W(INT_W), .RET_W(RET_W)) i_seq (
    .clk_i, .rst_ni, .halt_i(halt_o), .force_i(force_w), .interval_i(interval_o),
    .empty_i(empty_w), .head_i(head_w), .all_matched_i(all_matched_w),
    .load_o(load_w), .cur_valid_o, .cur_evt_o, .rid_o(req_id_o),
    .retry_o(retry_cnt_o), .req_o(req_valid_o)
  );

  evm_match #(.CH_N(CH_N), .ID_W(ID_W), .RID_W(RID_W)) i_match (
    .clk_i, .rst_ni, .clear_i(load_w), .cur_valid_i(cur_valid_o),
    .cur_evt_i(cur_evt_o), .rid_i(req_id_o), .reply_valid_i, .reply_ch_i,
    .reply_rid_i, .reply_evt_i, .chan_en_i(chan_en_o),
    .matched_o, .all_matched_o(all_matched_w)
  );

  assign req_word_o = {BCAST_CH, 8'(req_id_o)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          newest_evt_o <= '0;
    else if (evt_valid_i) newest_evt_o <= evt_id_i;
  end
endmodule

// File: rtl/evm_checker.sv
module evm_checker #(
  parameter int CH_N  = 4,
  parameter int DEPTH = 8,
  parameter int RID_W = 4,
  parameter int RET_W = 16,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic [15:0]      req_word_o,
  input logic             cur_valid_o,
  input logic [CNT_W-1:0] fifo_cnt_o,
  input logic             overflow_o,
  input logic [RID_W-1:0] req_id_o,
  input logic [RET_W-1:0] retry_cnt_o,
  input logic [CH_N-1:0]  matched_o,
  input logic             halt_o,
  input logic             reply_valid_i,
  input logic [RID_W-1:0] reply_rid_i
);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_o <= CNT_W'(DEPTH));

  a_r2_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r3_retry_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_id_o != $past(req_id_o)) |-> (retry_cnt_o == '0 && matched_o == '0 && cur_valid_o));

  a_r4_req_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_word_o[15:8] >= 8'(CH_N) && req_word_o[7:0] == 8'(req_id_o) && cur_valid_o));

  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  a_r6_match_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((matched_o & ~$past(matched_o)) != '0) |-> $past(reply_valid_i && reply_rid_i == req_id_o));

  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o)) |-> !req_valid_o);
endmodule

bind evt_match_ctrl evm_checker #(
  .CH_N(CH_N), .DEPTH(DEPTH), .RID_W(RID_W), .RET_W(RET_W), .CNT_W(CNT_W)
) i_evm_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_o(req_valid_o), .req_word_o(req_word_o),
  .cur_valid_o(cur_valid_o), .fifo_cnt_o(fifo_cnt_o), .overflow_o(overflow_o),
  .req_id_o(req_id_o), .retry_cnt_o(retry_cnt_o), .matched_o(matched_o),
  .halt_o(halt_o), .reply_valid_i(reply_valid_i), .reply_rid_i(reply_rid_i)
);

// File: tb/test_evt_match_ctrl.sv
`timescale 1ns/1ps
module test_evt_match_ctrl;
  localparam int ID_W = 36, CH_N = 4, DEPTH = 8, RID_W = 4, INT_W = 16, RET_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             evt_valid = 0;
  logic [ID_W-1:0]  evt_id = '0;
  logic             reply_valid = 0;
  logic [7:0]       reply_ch = '0;
  logic [RID_W-1:0] reply_rid = '0;
  logic [ID_W-1:0]  reply_evt = '0;
  logic             wr_en = 0;
  logic [1:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic             req_valid, cur_valid, overflow, halt;
  logic [15:0]      req_word;
  logic [ID_W-1:0]  cur_evt, newest_evt;
  logic [CNT_W-1:0] fifo_cnt;
  logic [RID_W-1:0] req_id;
  logic [RET_W-1:0] retry_cnt;
  logic [CH_N-1:0]  matched, chan_en;
  logic [INT_W-1:0] interval;

  evt_match_ctrl i_evt_match_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_id_i(evt_id),
    .reply_valid_i(reply_valid), .reply_ch_i(reply_ch), .reply_rid_i(reply_rid),
    .reply_evt_i(reply_evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .req_valid_o(req_valid), .req_word_o(req_word), .cur_valid_o(cur_valid),
    .cur_evt_o(cur_evt), .newest_evt_o(newest_evt), .fifo_cnt_o(fifo_cnt),
    .overflow_o(overflow), .req_id_o(req_id), .retry_cnt_o(retry_cnt),
    .matched_o(matched), .halt_o(halt), .interval_o(interval), .chan_en_o(chan_en)
  );

  int n_chk = 0, n_fail = 0;
  longint cyc = 0, last_p = 0, prev_p = 0;
  int pulses = 0;
  logic [15:0] last_word = '0;
  logic [RID_W-1:0] exp_rid = '0;

  always @(posedge clk) begin
    cyc++;
    if (req_valid) begin
      prev_p = last_p;
      last_p = cyc;
      pulses++;
      last_word = req_word;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic push_evt(input logic [ID_W-1:0] id);
    @(negedge clk); evt_valid = 1; evt_id = id;
    @(negedge clk); evt_valid = 0;
  endtask

  task automatic reply(input int ch, input logic [RID_W-1:0] rid, input logic [ID_W-1:0] e);
    @(negedge clk); reply_valid = 1; reply_ch = 8'(ch); reply_rid = rid; reply_evt = e;
    @(negedge clk); reply_valid = 0;
  endtask

  task automatic wait_cur(input logic [ID_W-1:0] e);
    for (int i = 0; i < 40; i++) begin
      if (cur_valid && cur_evt == e) break;
      @(negedge clk);
    end
  endtask

  localparam logic [ID_W-1:0] EA = 36'h1_0000_00A1, EB = 36'h2_0000_00B2;
  localparam logic [ID_W-1:0] EC = 36'h3_0000_00C3, ED = 36'h4_0000_00D4;

  task automatic t_reset;
    chk(halt == 1'b1, "R8 halt reset", halt, 1);
    chk(interval == 16'h07FF, "R10 interval reset", interval, 16'h07FF);
    chk(chan_en == '1, "R10 enable reset", chan_en, 4'hF);
    chk(fifo_cnt == 0 && !cur_valid && !overflow, "R1 empty reset",
        {fifo_cnt, cur_valid, overflow}, 0);
  endtask

  task automatic t_halt_hold;
    int p0;
    push_evt(EA);
    push_evt(EB);
    chk(fifo_cnt == 2, "R1 fifo count", fifo_cnt, 2);
    chk(newest_evt == EB, "R1 newest id", newest_evt, EB);
    p0 = pulses;
    idle(20);
    chk(pulses == p0 && !cur_valid, "R8 no request while halted", pulses - p0, 0);
  endtask

  task automatic t_run;
    int p0;
    host_wr(2'd2, 16'd3);
    host_wr(2'd0, 16'd0);
    p0 = pulses;
    wait_cur(EA);
    exp_rid = exp_rid + 1'b1;
    chk(cur_evt == EA && fifo_cnt == 1, "R1 oldest loaded, count excludes current", cur_evt, EA);
    chk(req_id == exp_rid && matched == 0, "R3 tag on load", req_id, exp_rid);
    for (int i = 0; i < 40 && pulses < p0 + 2; i++) @(negedge clk);
    chk(last_p - prev_p == 5, "R5 request spacing", last_p - prev_p, 5);
    chk(last_word == {8'hFF, 8'(exp_rid)}, "R4 request word", last_word, {8'hFF, 8'(exp_rid)});
    chk(retry_cnt == 2, "R4 retry count", retry_cnt, 2);
    reply(0, exp_rid, EA);
    reply(1, exp_rid, EA);
    reply(2, exp_rid, EA);
    reply(3, exp_rid - 1'b1, EA);
    reply(3, exp_rid, EB);
    chk(matched == 4'b0111 && cur_evt == EA, "R6 stale replies ignored", matched, 4'b0111);
    reply(3, exp_rid, EA);
    wait_cur(EB);
    exp_rid = exp_rid + 1'b1;
    chk(cur_evt == EB && fifo_cnt == 0, "R7 advance when all matched", cur_evt, EB);
    chk(req_id == exp_rid && matched == 0 && retry_cnt == 0, "R3 state on new event",
        {req_id, matched, retry_cnt}, {exp_rid, 4'b0, 16'b0});
  endtask

  task automatic t_disabled;
    host_wr(2'd3, 16'b0101);
    reply(0, exp_rid, EB);
    reply(2, exp_rid, EB);
    for (int i = 0; i < 20 && cur_valid; i++) @(negedge clk);
    chk(!cur_valid, "R7 disabled channels excluded", cur_valid, 0);
    host_wr(2'd3, 16'hF);
  endtask

  task automatic t_force;
    int p0;
    push_evt(EC);
    push_evt(ED);
    wait_cur(EC);
    exp_rid = exp_rid + 1'b1;
    host_wr(2'd1, 16'd1);
    idle(2);
    chk(cur_evt == EC && req_id == exp_rid, "R9 force ignored when running", cur_evt, EC);
    host_wr(2'd0, 16'd1);
    idle(3);
    p0 = pulses;
    idle(20);
    chk(pulses == p0, "R8 halt stops requests", pulses - p0, 0);
    host_wr(2'd1, 16'd1);
    exp_rid = exp_rid + 1'b1;
    chk(cur_evt == ED && req_id == exp_rid && retry_cnt == 0, "R9 force advances unmatched",
        cur_evt, ED);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH + 1; i++) push_evt(36'h5_0000_0000 + 36'(i));
    chk(fifo_cnt == DEPTH, "R2 count saturates", fifo_cnt, DEPTH);
    chk(overflow == 1'b1, "R2 overflow flag", overflow, 1);
    chk(newest_evt == 36'h5_0000_0008, "R1 newest after drop", newest_evt, 36'h5_0000_0008);
    host_wr(2'd1, 16'd1);
    exp_rid = exp_rid + 1'b1;
    chk(cur_evt == 36'h5_0000_0000 && fifo_cnt == DEPTH - 1, "R1 first-in first-out",
        cur_evt, 36'h5_0000_0000);
  endtask

  task automatic t_wrap;
    for (int i = 1; i < DEPTH; i++) host_wr(2'd1, 16'd1);
    exp_rid = exp_rid + RID_W'(DEPTH - 1);
    chk(cur_evt == 36'h5_0000_0007 && req_id == exp_rid, "R3 tag per load", req_id, exp_rid);
    for (int i = 0; i < 4; i++) push_evt(36'h6_0000_0000 + 36'(i));
    for (int i = 0; i < 4; i++) host_wr(2'd1, 16'd1);
    exp_rid = exp_rid + RID_W'(4);
    chk(req_id == exp_rid && exp_rid == 0, "R3 tag wraps to 0", req_id, exp_rid);
    chk(cur_evt == 36'h6_0000_0003, "R9 force sequence", cur_evt, 36'h6_0000_0003);
    chk(overflow == 1'b1, "R2 overflow sticky", overflow, 1);
    host_wr(2'd1, 16'd1);
    chk(!cur_valid, "R9 force with empty queue", cur_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_halt_hold();
    t_run();
    t_disabled();
    t_force();
    t_overflow();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule